// File: doc/BRIEF.md
# Bus-Mapped Serial Byte Port

A slave on a 32-bit Wishbone bus that uses classic cycles and carries one asynchronous serial byte in each direction. It has no queueing. The port has one transmit shifter and one receive holding register. Two status flip-flops sit beside them: one reports that the transmitter is idle, the other reports that a received byte is waiting. Software reaches the port through two word addresses, a data word and a status word. All payload and status bits travel on the most significant byte lane of the bus.

A store to the data word starts a frame, and a load from the data word fetches the most recently received byte. The line format is fixed: one start bit, eight data bits sent least significant first, one stop bit, and no parity. Each bit lasts a number of clock cycles set by a parameter. At a 40 MHz clock and 115200 baud that number is about 347. Reads and writes use separate buses, and there are no tristate drivers.

Top module: `bus_uart_port`

## Requirements
- R1: During and after reset the port holds `wb_ack_o` low and `ser_tx_o` high. The status word reads 0x0200_0000 and the data word reads 0x0000_0000.
- R2: The port answers only addresses whose bits 31..3 equal those of `BASE_ADDR`. Address bit 2 = 0 selects the data word and bit 2 = 1 selects the status word. With `wb_cyc_i` and `wb_stb_i` high on a matching address, `wb_ack_o` rises one cycle later for exactly one cycle. Other addresses get no acknowledge.
- R3: The status word has bit 25 = transmitter idle and bit 24 = received byte waiting, with every other bit 0. Writes to the status word are acknowledged and have no effect.
- R4: A write to the data word with `wb_sel_i[3]` high while the transmitter is idle sends `wb_dat_i[31:24]`. The frame is a low start bit, the eight data bits least significant first and a high stop bit, each held for `BIT_CLKS` cycles. The idle flag reads 0 from the next cycle until the stop bit ends.
- R5: A data write with `wb_sel_i[3]` low, or a data write made while a frame is being sent, is acknowledged but changes nothing on `ser_tx_o`.
- R6: A valid received frame places its byte in bits 31..24 of the data word, with all other bits 0, and sets the byte-waiting flag.
- R7: An acknowledged data read with `wb_sel_i[3]` high clears the byte-waiting flag. A data read with `wb_sel_i[3]` low returns the word and leaves the flag set.
- R8: If a frame completes in the same cycle as a clearing read, the flag stays set. That read returns the earlier byte.
- R9: A frame whose stop bit samples low is discarded: neither the byte nor the flag changes.
- R10: A low pulse on `ser_rx_i` that has ended by the middle of the start bit is treated as noise, and the receiver returns to idle.
- R11: A frame received while the flag is already set replaces the stored byte, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 32 | Byte address |
| wb_sel_i | input | 4 | Byte lane enables, bit 3 = bits 31..24 |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid while acknowledged |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| ser_tx_o | output | 1 | Serial transmit line, idle high |
| ser_rx_i | input | 1 | Serial receive line, idle high |

## Verification
Two events can land in the same clock cycle: the receiver finishing a frame, and a bus read of the data word clearing the byte-waiting flag. The bench forces this by holding a data read open across an incoming frame. With the strobe held high, acknowledges fall on alternate cycles, and the bench repeats the frame at two start offsets one cycle apart so that one run puts frame completion on an acknowledge cycle. Each run is judged by one rule: either one of the polled reads returned the new byte, or the status word still shows the flag set afterwards, and never both.

// File: rtl/wbu_pkg.sv
package wbu_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int unsigned STAT_IDLE_BIT = 25;
  localparam int unsigned STAT_FULL_BIT = 24;

  // status word: idle flag and full flag on the top lane
  function automatic logic [31:0] pack_status(input logic tx_idle, input logic rx_full);
    logic [31:0] w;
    w = '0;
    w[STAT_IDLE_BIT] = tx_idle;
    w[STAT_FULL_BIT] = rx_full;
    return w;
  endfunction

  // data word: byte placed on bits 31..24
  function automatic logic [31:0] pack_data(input logic [7:0] b);
    return {b, 24'h00_0000};
  endfunction

  // serial frame, bit 0 leaves first: start, data LSB first, stop
  function automatic logic [9:0] make_frame(input logic [7:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  function automatic logic addr_hit(input logic [31:0] adr, input logic [31:0] base);
    return adr[31:3] == base[31:3];
  endfunction

endpackage

// File: rtl/wbu_bus_if.sv
module wbu_bus_if
  import wbu_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h9000_0000
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        cyc_i,
  input  logic        stb_i,
  input  logic        we_i,
  input  logic [31:0] adr_i,
  input  logic [3:0]  sel_i,
  input  logic [31:0] dat_i,
  output logic [31:0] dat_o,
  output logic        ack_o,
  input  logic        tx_idle_i,
  input  logic        rx_full_i,
  input  logic [7:0]  rx_byte_i,
  output logic        tx_load_o,
  output logic [7:0]  tx_byte_o,
  output logic        rx_clear_o
);

  logic access;
  logic is_data;
  logic unused_bits;

  assign unused_bits = ^{dat_i[23:0], adr_i[1:0], sel_i[2:0]};

  // one access per acknowledge: the registered ack masks the following cycle
  assign access  = cyc_i & stb_i & addr_hit(adr_i, BASE_ADDR) & ~ack_o;
  assign is_data = ~adr_i[2];

  assign tx_load_o  = access & we_i & is_data & sel_i[3] & tx_idle_i;
  assign tx_byte_o  = dat_i[31:24];
  assign rx_clear_o = access & ~we_i & is_data & sel_i[3];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ack_o <= 1'b0;
      dat_o <= '0;
    end else begin
      ack_o <= access;
      if (access && !we_i) begin
        dat_o <= is_data ? pack_data(rx_byte_i) : pack_status(tx_idle_i, rx_full_i);
      end else begin
        dat_o <= '0;
      end
    end
  end

endmodule

// File: rtl/wbu_tx.sv
module wbu_tx
  import wbu_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 347
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       idle_o,
  output logic       tx_o
);

  localparam int unsigned CW = $clog2(BIT_CLKS);
  localparam logic [CW-1:0] CNT_TOP = CW'(BIT_CLKS - 1);

  logic [9:0]    shreg;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [3:0]    left;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      shreg <= '1;
      busy  <= 1'b0;
      cnt   <= '0;
      left  <= '0;
    end else if (!busy) begin
      if (load_i) begin
        shreg <= make_frame(byte_i);
        busy  <= 1'b1;
        cnt   <= CNT_TOP;
        left  <= 4'd9;
      end
    end else if (cnt == '0) begin
      cnt <= CNT_TOP;
      if (left == 4'd0) begin
        busy <= 1'b0;
      end else begin
        shreg <= {1'b1, shreg[9:1]};
        left  <= left - 4'd1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign idle_o = ~busy;
  assign tx_o   = busy ? shreg[0] : 1'b1;

endmodule

// File: rtl/wbu_rx.sv
module wbu_rx
  import wbu_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 347
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       rx_i,
  input  logic       clear_i,
  output logic [7:0] byte_o,
  output logic       full_o,
  output logic       done_o
);

  localparam int unsigned CW = $clog2(BIT_CLKS);
  localparam logic [CW-1:0] CNT_TOP  = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] HALF_TOP = CW'(BIT_CLKS / 2 - 1);

  logic          rx_meta, rx_s;
  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shreg;
  logic          tick;

  assign tick   = (cnt == '0);
  assign done_o = (state == RX_STOP) & tick & rx_s;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rx_i;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (!rx_s) begin
            state <= RX_START;
            cnt   <= HALF_TOP;
          end
        end
        RX_START: begin
          if (tick) begin
            if (!rx_s) begin
              state <= RX_DATA;
              cnt   <= CNT_TOP;
              idx   <= '0;
            end else begin
              state <= RX_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_DATA: begin
          if (tick) begin
            shreg <= {rx_s, shreg[7:1]};
            cnt   <= CNT_TOP;
            idx   <= idx + 3'd1;
            if (idx == 3'd7) state <= RX_STOP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (tick) state <= RX_IDLE;
          else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  // completion has priority over the bus clear
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      byte_o <= '0;
      full_o <= 1'b0;
    end else if (done_o) begin
      byte_o <= shreg;
      full_o <= 1'b1;
    end else if (clear_i) begin
      full_o <= 1'b0;
    end
  end

endmodule

// File: rtl/bus_uart_port.sv
module bus_uart_port
  import wbu_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h9000_0000,
  parameter int unsigned BIT_CLKS  = 347
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic [31:0] wb_adr_i,
  input  logic [3:0]  wb_sel_i,
  input  logic [31:0] wb_dat_i,
  output logic [31:0] wb_dat_o,
  output logic        wb_ack_o,
  output logic        ser_tx_o,
  input  logic        ser_rx_i
);

  logic       tx_load, tx_idle, rx_clear, rx_full, rx_done;
  logic [7:0] tx_byte, rx_byte;

  wbu_bus_if #(.BASE_ADDR(BASE_ADDR)) u_bus (
    .clk_i(clk_i), .rst_i(rst_i),
    .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .we_i(wb_we_i),
    .adr_i(wb_adr_i), .sel_i(wb_sel_i), .dat_i(wb_dat_i),
    .dat_o(wb_dat_o), .ack_o(wb_ack_o),
    .tx_idle_i(tx_idle), .rx_full_i(rx_full), .rx_byte_i(rx_byte),
    .tx_load_o(tx_load), .tx_byte_o(tx_byte), .rx_clear_o(rx_clear)
  );

  wbu_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
    .clk_i(clk_i), .rst_i(rst_i),
    .load_i(tx_load), .byte_i(tx_byte),
    .idle_o(tx_idle), .tx_o(ser_tx_o)
  );

  wbu_rx #(.BIT_CLKS(BIT_CLKS)) u_rx (
    .clk_i(clk_i), .rst_i(rst_i),
    .rx_i(ser_rx_i), .clear_i(rx_clear),
    .byte_o(rx_byte), .full_o(rx_full), .done_o(rx_done)
  );

endmodule

// File: rtl/wbu_checker.sv
module wbu_checker (
  input logic clk_i,
  input logic rst_i,
  input logic cyc_i,
  input logic stb_i,
  input logic ack_i,
  input logic tx_line,
  input logic tx_load,
  input logic tx_idle,
  input logic rx_clear,
  input logic rx_done,
  input logic rx_full
);

  // R2
  ack_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_i |=> !ack_i);

  // R2
  ack_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_i |-> $past(cyc_i && stb_i));

  // R4
  load_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_load |=> !tx_idle);

  // R4
  idle_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_idle |-> tx_line);

  // R6
  done_sets_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rx_done |=> rx_full);

  // R7
  clear_drops_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rx_clear && !rx_done) |=> !rx_full);

endmodule

bind bus_uart_port wbu_checker u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .cyc_i(wb_cyc_i), .stb_i(wb_stb_i),
  .ack_i(wb_ack_o), .tx_line(ser_tx_o), .tx_load(tx_load), .tx_idle(tx_idle),
  .rx_clear(rx_clear), .rx_done(rx_done), .rx_full(rx_full)
);

// File: tb/test_bus_uart_port.sv
module test_bus_uart_port;

  localparam time         CLK_PERIOD = 25ns;
  localparam int unsigned DIV        = 16;
  localparam logic [31:0] BASE       = 32'h9000_0000;
  localparam logic [31:0] A_DATA     = BASE;
  localparam logic [31:0] A_STAT     = BASE + 32'd4;
  localparam logic [31:0] ST_IDLE    = 32'h0200_0000;
  localparam logic [31:0] ST_FULL    = 32'h0300_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc = 0, stb = 0, we = 0;
  logic [31:0] adr = '0, wdat = '0;
  logic [3:0] sel = '0;
  logic [31:0] rdat;
  logic ack, txl;
  logic rxl = 1'b1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_uart_port #(.BASE_ADDR(BASE), .BIT_CLKS(DIV)) i_bus_uart_port (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(rdat),
    .wb_ack_o(ack), .ser_tx_o(txl), .ser_rx_i(rxl)
  );

  typedef struct packed {
    logic        w;
    logic [31:0] a;
    logic [3:0]  s;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  req;
  } vec_t;

  // R1 R3 R5 table entries
  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_STAT, 4'hF, 32'h0,          ST_IDLE, 4'd1},
    '{1'b0, A_DATA, 4'h8, 32'h0,          32'h0,   4'd1},
    '{1'b1, A_STAT, 4'hF, 32'hFFFF_FFFF,  32'h0,   4'd3},
    '{1'b0, A_STAT, 4'hF, 32'h0,          ST_IDLE, 4'd3},
    '{1'b1, A_DATA, 4'h7, 32'h5500_0000,  32'h0,   4'd5},
    '{1'b0, A_STAT, 4'hF, 32'h0,          ST_IDLE, 4'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [31:0] a, input logic [3:0] s,
                     input logic [31:0] d, output logic [31:0] rd, output logic acked);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; sel = s; wdat = d;
    acked = 0; rd = '0;
    for (int i = 0; i < 6 && !acked; i++) begin
      @(negedge clk);
      if (ack) begin acked = 1; rd = rdat; end
    end
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic send_serial(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxl = f[i];
      repeat (DIV - 1) @(negedge clk);
    end
    @(negedge clk); rxl = 1'b1;
  endtask

  task automatic capture_tx(output logic [7:0] b, output logic stop);
    while (txl !== 1'b0) @(negedge clk);
    repeat (DIV/2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = txl;
    end
    repeat (DIV) @(negedge clk);
    stop = txl;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic ok, stp, saw;
    logic [7:0] cb;
    logic [7:0] txv [2];
    txv[0] = 8'hA5; txv[1] = 8'h81;

    repeat (4) @(negedge clk);
    // R1 reset values at the ports
    check("R1 ack in reset", {31'b0, ack}, 32'h0);
    check("R1 tx in reset", {31'b0, txl}, 32'h1);
    @(negedge clk); rst = 0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      bus(VEC[v].w, VEC[v].a, VEC[v].s, VEC[v].d, rd, ok);
      check($sformatf("R%0d table ack %0d", VEC[v].req, v), {31'b0, ok}, 32'h1);
      if (!VEC[v].w) check($sformatf("R%0d table data %0d", VEC[v].req, v), rd, VEC[v].e);
    end

    // R2 unmapped address never acknowledged
    bus(1'b0, 32'h9000_0010, 4'hF, 32'h0, rd, ok);
    check("R2 unmapped ack", {31'b0, ok}, 32'h0);
    // R5 line stayed idle after lane-less write
    stp = 1;
    for (int i = 0; i < 2*DIV; i++) begin @(negedge clk); if (txl !== 1'b1) stp = 0; end
    check("R5 no frame without lane 3", {31'b0, stp}, 32'h1);

    // R4 transmit two patterns, R5 busy write ignored
    for (int k = 0; k < 2; k++) begin
      fork
        capture_tx(cb, stp);
        begin
          bus(1'b1, A_DATA, 4'h8, {txv[k], 24'h0}, rd, ok);
          bus(1'b0, A_STAT, 4'hF, 32'h0, rd, ok);
          check("R4 idle flag low while sending", rd, 32'h0);
          bus(1'b1, A_DATA, 4'h8, 32'h3C00_0000, rd, ok);
          check("R5 busy write acked", {31'b0, ok}, 32'h1);
        end
      join
      check("R4 transmitted byte", {24'h0, cb}, {24'h0, txv[k]});
      check("R4 stop bit", {31'b0, stp}, 32'h1);
      repeat (DIV) @(negedge clk);
      bus(1'b0, A_STAT, 4'hF, 32'h0, rd, ok);
      check("R4 idle after stop", rd, ST_IDLE);
      ok = 1;
      for (int i = 0; i < 12*DIV; i++) begin @(negedge clk); if (txl !== 1'b1) ok = 0; end
      check("R5 busy write sent nothing", {31'b0, ok}, 32'h1);
    end

    // R6 receive, R7 clear
    send_serial(8'h5A, 1'b1);
    bus(1'b0, A_STAT, 4'hF, 32'h0, rd, ok);
    check("R6 full flag set", rd, ST_FULL);
    bus(1'b0, A_DATA, 4'h7, 32'h0, rd, ok);
    check("R7 lane-less read data", rd, 32'h5A00_0000);
    bus(1'b0, A_STAT, 4'hF, 32'h0, rd, ok);
    check("R7 lane-less read keeps flag", rd, ST_FULL);
    bus(1'b0, A_DATA, 4'h8, 32'h0, rd, ok);
    check("R6 received byte", rd, 32'h5A00_0000);
    bus(1'b0, A_STAT, 4'hF, 32'h0, rd, ok);
    check("R7 flag cleared", rd, ST_IDLE);

    // R9 framing error discarded
    send_serial(8'hE7, 1'b0);
    repeat (2*DIV) @(negedge clk);
    bus(1'b0, A_STAT, 4'hF, 32'h0, rd, ok);
    check("R9 bad stop flag", rd, ST_IDLE);
    bus(1'b0, A_DATA, 4'h8, 32'h0, rd, ok);
    check("R9 bad stop byte", rd, 32'h5A00_0000);

    // R10 short glitch rejected, then a good frame
    @(negedge clk); rxl = 0;
    repeat (DIV/4) @(negedge clk);
    rxl = 1;
    repeat (12*DIV) @(negedge clk);
    bus(1'b0, A_STAT, 4'hF, 32'h0, rd, ok);
    check("R10 glitch no frame", rd, ST_IDLE);
    send_serial(8'h96, 1'b1);
    bus(1'b0, A_DATA, 4'h8, 32'h0, rd, ok);
    check("R10 frame after glitch", rd, 32'h9600_0000);

    // R11 overwrite while full
    send_serial(8'h21, 1'b1);
    send_serial(8'h7E, 1'b1);
    bus(1'b0, A_STAT, 4'hF, 32'h0, rd, ok);
    check("R11 flag stays set", rd, ST_FULL);
    bus(1'b0, A_DATA, 4'h8, 32'h0, rd, ok);
    check("R11 newest byte", rd, 32'h7E00_0000);

    // R8 completion against clearing read, two phase offsets
    for (int off = 0; off < 2; off++) begin
      saw = 0;
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = A_DATA; sel = 4'h8;
      fork
        begin repeat (off + 3) @(negedge clk); send_serial(8'hC3, 1'b1); end
        for (int i = 0; i < off + 3 + 11*DIV + 8; i++) begin
          @(negedge clk);
          if (ack && rdat == 32'hC300_0000) saw = 1;
        end
      join
      cyc = 0; stb = 0;
      repeat (2) @(negedge clk);
      bus(1'b0, A_STAT, 4'hF, 32'h0, rd, ok);
      check($sformatf("R8 seen xor pending off %0d", off), {31'b0, saw ^ rd[24]}, 32'h1);
      bus(1'b0, A_DATA, 4'h8, 32'h0, rd, ok);
      check("R8 byte kept", rd, 32'hC300_0000);
      bus(1'b0, A_DATA, 4'h8, 32'h0, rd, ok);
      bus(1'b0, A_DATA, 4'h8, 32'h0, rd, ok);
      check("R8 byte stored", rd, 32'hC300_0000);
      // reset stored byte to a different value for the next offset
      send_serial(8'h11, 1'b1);
      bus(1'b0, A_DATA, 4'h8, 32'h0, rd, ok);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule